// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single reservation that a 32-bit core needs for its load-reserve and store-conditional pair. Every cycle it watches a small, already decoded stream of memory operations, up to `LANES` of them in program order. Each lane carries a valid bit, the 6-bit major opcode, a ready-made effective address and the store data. A load-reserve arms the reservation with its address. An ordinary store of any size to the reserved word disarms it. A store-conditional is tested against the reservation and always disarms it.

For a store-conditional the block decides whether the memory write may happen. On success it drives one full-word write request toward memory. It also produces a success flag that the core copies into its status-register flag bit. The flag stays unchanged until the next store-conditional. Address arithmetic, the memory array, snooping by other masters and exceptions belong to neighbouring blocks.

Top module: `lrsc_monitor`

## Requirements
- R1: Each lane's 6-bit opcode decodes as follows: 0x1B is a load-reserve, 0x33 is a store-conditional, and 0x35 (word), 0x36 (byte) and 0x37 (halfword) are ordinary stores. Any other opcode, and any lane whose valid bit is low, leaves every output unchanged.
- R2: A load-reserve makes `rsv_valid` 1 and `rsv_addr` equal to its full effective address in the cycle after it is presented.
- R3: A store-conditional succeeds only when the reservation is valid and its address equals `rsv_addr` in all 32 bits. The test uses the reservation as it stood at the start of that cycle.
- R4: A successful store-conditional produces a one-cycle `mem_we` pulse in the next cycle, with `mem_strb` all ones, its address on `mem_addr` and its data on `mem_wdata`. A failing one leaves `mem_we` and `mem_strb` at 0.
- R5: A store-conditional clears `rsv_valid` in the next cycle, whether it succeeds or fails.
- R6: An ordinary store clears the reservation when its address with bits 1..0 forced to zero equals `rsv_addr`. Any other ordinary store leaves the reservation unchanged.
- R7: When a load-reserve and a clearing event fall in the same cycle, the load-reserve wins and the new reservation is armed.
- R8: With several lanes active in one cycle, the store-conditional in the lowest-numbered lane is the one evaluated. The load-reserve in the highest-numbered lane is the one recorded.
- R9: `sc_flag` takes the result of a store-conditional one cycle after the request and holds it until the next store-conditional.
- R10: Under reset (`rst_n` low at a clock edge) `rsv_valid`, `rsv_addr`, `sc_flag` and `mem_we` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | LANES | Per-lane operation valid |
| op_code | input | 6*LANES | Per-lane major opcode, lane 0 in the low bits |
| op_addr | input | AW*LANES | Per-lane effective address |
| op_data | input | DW*LANES | Per-lane store data |
| mem_we | output | 1 | Store-conditional write request |
| mem_strb | output | DW/8 | Byte strobes for the write |
| mem_addr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| sc_flag | output | 1 | Last store-conditional result, for the status flag |
| rsv_valid | output | 1 | Reservation armed |
| rsv_addr | output | AW | Reserved address |

## Verification
On every cycle the assertions check several rules. A load-reserve always leaves the reservation armed, even beside a clearing event. A lone store-conditional always disarms it. The reservation holds still when no event touches it. A write request never appears without a set flag, and the flag holds between store-conditionals. Only the bench's scenarios can show which address wins across lanes and that stores to a neighbouring word leave the reservation alone. They also show the masked comparison for an unaligned reservation and the exact data and address carried to memory on success.

// File: rtl/lrsc_pkg.sv
// Shared opcode values and operation classification for the reservation monitor.
// Assumes the 6-bit major opcode has already been extracted from the instruction.
package lrsc_pkg;
    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_LOAD_RSV   = 6'h1B;
    localparam logic [OPC_W-1:0] OPC_STORE_COND = 6'h33;
    localparam logic [OPC_W-1:0] OPC_ST_WORD    = 6'h35;
    localparam logic [OPC_W-1:0] OPC_ST_BYTE    = 6'h36;
    localparam logic [OPC_W-1:0] OPC_ST_HALF    = 6'h37;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_LOAD_RSV,
        KIND_STORE_COND,
        KIND_PLAIN_STORE
    } op_kind_e;

    // Map a major opcode to the operation class the monitor cares about.
    function automatic op_kind_e classify_op(input logic [OPC_W-1:0] code);
        op_kind_e k;
        case (code)
            OPC_LOAD_RSV:                          k = KIND_LOAD_RSV;
            OPC_STORE_COND:                        k = KIND_STORE_COND;
            OPC_ST_WORD, OPC_ST_BYTE, OPC_ST_HALF: k = KIND_PLAIN_STORE;
            default:                               k = KIND_NONE;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/lrsc_lane_decode.sv
// Per-lane decoder: classifies one operation and tests an ordinary store
// against the current reservation with the low two address bits masked.
// Assumes the reservation inputs are the registered state of this cycle.
module lrsc_lane_decode
    import lrsc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 lane_valid,
    input  logic [OPC_W-1:0]     lane_code,
    input  logic [AW-1:0]        lane_addr,
    input  logic [AW-1:0]        rsv_addr_i,
    output logic                 is_lr,
    output logic                 is_sc,
    output logic                 st_hit
);
    localparam int WORD_LSB = 2;

    op_kind_e kind;
    logic [AW-1:0] word_addr;

    // Classify the lane and form the word-aligned address of a plain store.
    always_comb begin
        kind      = lane_valid ? classify_op(lane_code) : KIND_NONE;
        word_addr = {lane_addr[AW-1:WORD_LSB], {WORD_LSB{1'b0}}};
        is_lr     = (kind == KIND_LOAD_RSV);
        is_sc     = (kind == KIND_STORE_COND);
        st_hit    = (kind == KIND_PLAIN_STORE) && (word_addr == rsv_addr_i);
    end
endmodule

// File: rtl/lrsc_rsv_reg.sv
// Reservation state: valid bit and address. A load-reserve arms it
// (highest lane wins); otherwise a clearing event disarms it.
// Assumes clr_any already merges store-conditionals and store hits.
module lrsc_rsv_reg #(
    parameter int AW    = 32,
    parameter int LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      lr_vec,
    input  logic [AW*LANES-1:0]   lane_addr,
    input  logic                  clr_any,
    input  logic                  sc_any,
    output logic                  rsv_valid,
    output logic [AW-1:0]         rsv_addr
);
    logic          lr_any;
    logic [AW-1:0] lr_addr;

    // Pick the load-reserve address of the highest-numbered active lane.
    always_comb begin
        lr_addr = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lr_vec[i]) lr_addr = lane_addr[i*AW +: AW];
        end
        lr_any = |lr_vec;
    end

    // Update the reservation; a load-reserve takes priority over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv_valid <= 1'b0;
            rsv_addr  <= '0;
        end else if (lr_any) begin
            rsv_valid <= 1'b1;
            rsv_addr  <= lr_addr;
        end else if (clr_any) begin
            rsv_valid <= 1'b0;
        end
    end

    a_r7_lr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lr_any |=> rsv_valid);

    a_r5_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_any && !lr_any) |=> !rsv_valid);

    a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lr_any && !clr_any) |=> ($stable(rsv_valid) && $stable(rsv_addr)));
endmodule

// File: rtl/lrsc_sc_port.sv
// Store-conditional evaluation: tests the lowest-lane store-conditional
// against the reservation held at the start of the cycle, registers the
// success flag and drives a one-cycle full-word write on success.
module lrsc_sc_port #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      sc_vec,
    input  logic [AW*LANES-1:0]   lane_addr,
    input  logic [DW*LANES-1:0]   lane_data,
    input  logic                  rsv_valid_i,
    input  logic [AW-1:0]         rsv_addr_i,
    output logic                  mem_we,
    output logic [DW/8-1:0]       mem_strb,
    output logic [AW-1:0]         mem_addr,
    output logic [DW-1:0]         mem_wdata,
    output logic                  sc_flag
);
    localparam int STRB_W = DW / 8;

    logic          sc_req;
    logic [AW-1:0] sc_addr;
    logic [DW-1:0] sc_data;
    logic          sc_ok;

    // Select the lowest-numbered store-conditional and test it.
    always_comb begin
        sc_addr = '0;
        sc_data = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (sc_vec[i]) begin
                sc_addr = lane_addr[i*AW +: AW];
                sc_data = lane_data[i*DW +: DW];
            end
        end
        sc_req = |sc_vec;
        sc_ok  = sc_req && rsv_valid_i && (sc_addr == rsv_addr_i);
    end

    // Register the flag (held between requests) and the write request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_flag   <= 1'b0;
            mem_we    <= 1'b0;
            mem_strb  <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            if (sc_req) sc_flag <= sc_ok;
            mem_we   <= sc_ok;
            mem_strb <= {STRB_W{sc_ok}};
            if (sc_ok) begin
                mem_addr  <= sc_addr;
                mem_wdata <= sc_data;
            end
        end
    end

    a_r4_write_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sc_flag);

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req |=> $stable(sc_flag));

    a_r3_unarmed_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !rsv_valid_i) |=> (!sc_flag && !mem_we));
endmodule

// File: rtl/lrsc_monitor.sv
// Top of the load-reserve / store-conditional monitor. Decodes LANES
// operations per cycle, derives the clearing event and ties the
// reservation register to the store-conditional port.
// Assumes lanes are in program order and addresses are already computed.
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        op_valid,
    input  logic [OPC_W*LANES-1:0]  op_code,
    input  logic [AW*LANES-1:0]     op_addr,
    input  logic [DW*LANES-1:0]     op_data,
    output logic                    mem_we,
    output logic [DW/8-1:0]         mem_strb,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    output logic                    sc_flag,
    output logic                    rsv_valid,
    output logic [AW-1:0]           rsv_addr
);
    logic [LANES-1:0] lr_vec;
    logic [LANES-1:0] sc_vec;
    logic [LANES-1:0] hit_vec;
    logic             clr_any;
    logic             sc_any;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lrsc_lane_decode #(.AW(AW)) u_dec (
            .lane_valid (op_valid[g]),
            .lane_code  (op_code[g*OPC_W +: OPC_W]),
            .lane_addr  (op_addr[g*AW +: AW]),
            .rsv_addr_i (rsv_addr),
            .is_lr      (lr_vec[g]),
            .is_sc      (sc_vec[g]),
            .st_hit     (hit_vec[g])
        );
    end

    // Merge the per-lane events that disarm the reservation.
    always_comb begin
        sc_any  = |sc_vec;
        clr_any = sc_any || (|hit_vec);
    end

    lrsc_rsv_reg #(.AW(AW), .LANES(LANES)) u_rsv (
        .clk       (clk),
        .rst_n     (rst_n),
        .lr_vec    (lr_vec),
        .lane_addr (op_addr),
        .clr_any   (clr_any),
        .sc_any    (sc_any),
        .rsv_valid (rsv_valid),
        .rsv_addr  (rsv_addr)
    );

    lrsc_sc_port #(.AW(AW), .DW(DW), .LANES(LANES)) u_sc (
        .clk         (clk),
        .rst_n       (rst_n),
        .sc_vec      (sc_vec),
        .lane_addr   (op_addr),
        .lane_data   (op_data),
        .rsv_valid_i (rsv_valid),
        .rsv_addr_i  (rsv_addr),
        .mem_we      (mem_we),
        .mem_strb    (mem_strb),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .sc_flag     (sc_flag)
    );
endmodule

// File: tb/lrsc_monitor_bench.sv
// Scoreboard bench: the driver applies one cycle of operations, updates a
// reference model built from the requirements and queues the expected
// outputs; the monitor compares them one cycle later at the falling edge.
module lrsc_monitor_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LANES = 2;
    localparam logic [5:0] C_LR = 6'h1B, C_SC = 6'h33, C_SW = 6'h35,
                           C_SB = 6'h36, C_SH = 6'h37, C_LD = 6'h21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES-1:0] op_valid = '0;
    logic [6*LANES-1:0] op_code = '0;
    logic [AW*LANES-1:0] op_addr = '0;
    logic [DW*LANES-1:0] op_data = '0;
    logic mem_we, sc_flag, rsv_valid;
    logic [DW/8-1:0] mem_strb;
    logic [AW-1:0] mem_addr, rsv_addr;
    logic [DW-1:0] mem_wdata;

    always #5 clk = ~clk;

    lrsc_monitor #(.AW(AW), .DW(DW), .LANES(LANES)) u_lrsc_monitor (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_data(op_data), .mem_we(mem_we),
        .mem_strb(mem_strb), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .sc_flag(sc_flag), .rsv_valid(rsv_valid), .rsv_addr(rsv_addr)
    );

    typedef struct {
        int          due;
        string       tag;
        logic        we;
        logic        flag;
        logic        rv;
        logic [31:0] ra;
        logic [31:0] wa;
        logic [31:0] wd;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    logic        m_rv = 1'b0;
    logic [31:0] m_ra = '0;
    logic        m_flag = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop the item due this cycle and compare every output.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            logic ok;
            e = q.pop_front();
            ok = (mem_we === e.we) && (sc_flag === e.flag) &&
                 (rsv_valid === e.rv) && (rsv_addr === e.ra) &&
                 (mem_strb === {4{e.we}}) &&
                 (!e.we || (mem_addr === e.wa && mem_wdata === e.wd));
            checks++;
            if (!ok) begin
                errors++;
                $display("FAIL %s: got we=%b strb=%h flag=%b rv=%b ra=%h wa=%h wd=%h exp we=%b flag=%b rv=%b ra=%h wa=%h wd=%h",
                         e.tag, mem_we, mem_strb, sc_flag, rsv_valid, rsv_addr, mem_addr, mem_wdata,
                         e.we, e.flag, e.rv, e.ra, e.wa, e.wd);
            end
        end
    end

    // Driver: apply one cycle of two lanes and queue the expected result.
    task automatic step(input logic v0, input logic [5:0] c0, input logic [31:0] a0, input logic [31:0] d0,
                        input logic v1, input logic [5:0] c1, input logic [31:0] a1, input logic [31:0] d1,
                        input string tag);
        exp_t e;
        logic v[2]; logic [5:0] c[2]; logic [31:0] a[2]; logic [31:0] d[2];
        logic sc_seen, ok, clr, lr_seen;
        logic [31:0] sa, sd, la;
        @(negedge clk);
        v[0] = v0; c[0] = c0; a[0] = a0; d[0] = d0;
        v[1] = v1; c[1] = c1; a[1] = a1; d[1] = d1;
        op_valid = {v1, v0};
        op_code  = {c1, c0};
        op_addr  = {a1, a0};
        op_data  = {d1, d0};
        sc_seen = 1'b0; lr_seen = 1'b0; clr = 1'b0; sa = '0; sd = '0; la = '0;
        for (int i = 0; i < 2; i++) begin
            if (v[i] && c[i] == C_SC && !sc_seen) begin
                sc_seen = 1'b1; sa = a[i]; sd = d[i];
            end
            if (v[i] && c[i] == C_SC) clr = 1'b1;
            if (v[i] && (c[i] == C_SW || c[i] == C_SB || c[i] == C_SH) &&
                ({a[i][31:2], 2'b00} == m_ra)) clr = 1'b1;
            if (v[i] && c[i] == C_LR) begin lr_seen = 1'b1; la = a[i]; end
        end
        ok = sc_seen && m_rv && (sa == m_ra);
        if (sc_seen) m_flag = ok;
        if (lr_seen) begin m_rv = 1'b1; m_ra = la; end
        else if (clr) m_rv = 1'b0;
        e.due = cyc + 1; e.tag = tag; e.we = ok; e.flag = m_flag;
        e.rv = m_rv; e.ra = m_ra; e.wa = sa; e.wd = sd;
        q.push_back(e);
    endtask

    task automatic one(input logic [5:0] c, input logic [31:0] a, input logic [31:0] d, input string tag);
        step(1'b1, c, a, d, 1'b0, 6'h00, 32'h0, 32'h0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 6'h00, 32'h0, 32'h0, 1'b0, 6'h00, 32'h0, 32'h0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R10 reset state
        if (mem_we !== 1'b0 || sc_flag !== 1'b0 || rsv_valid !== 1'b0 || rsv_addr !== 32'h0 || mem_strb !== 4'h0) begin
            errors++;
            $display("FAIL R10: got we=%b flag=%b rv=%b ra=%h exp all zero", mem_we, sc_flag, rsv_valid, rsv_addr);
        end
        rst_n = 1'b1;

        // Success path
        one(C_LR, 32'h0000_0100, 32'h0, "R2 arm");
        one(C_SC, 32'h0000_0100, 32'hCAFE_0001, "R3 R4 success");
        idle("R5 cleared after success");
        idle("R9 flag held");
        // Failure on address mismatch
        one(C_LR, 32'h0000_0200, 32'h0, "R2 arm second");
        one(C_SC, 32'h0000_0204, 32'hDEAD_0002, "R3 mismatch fails R5");
        idle("R9 fail flag held");
        // Intervening byte store to the reserved word
        one(C_LR, 32'h0000_0300, 32'h0, "R2 arm third");
        one(C_SB, 32'h0000_0302, 32'h11, "R6 byte store hit");
        one(C_SC, 32'h0000_0300, 32'h3333_3333, "R3 after kill fails");
        // Store to a different word keeps the reservation
        one(C_LR, 32'h0000_0400, 32'h0, "R2 arm fourth");
        one(C_SW, 32'h0000_0404, 32'h44, "R6 other word kept");
        one(C_SH, 32'h0000_03FE, 32'h45, "R6 halfword other word kept");
        one(C_SC, 32'h0000_0400, 32'h4444_4444, "R4 success after other store");
        // Ignored opcodes and invalid lanes
        one(C_LR, 32'h0000_0500, 32'h0, "R2 arm fifth");
        one(C_LD, 32'h0000_0500, 32'h0, "R1 plain load ignored");
        step(1'b0, C_SC, 32'h0000_0500, 32'h5, 1'b0, C_SW, 32'h0000_0500, 32'h5, "R1 invalid lanes ignored");
        one(C_SH, 32'h0000_0501, 32'h55, "R6 halfword hit");
        // Load-reserve beats a same-cycle clear
        one(C_LR, 32'h0000_0600, 32'h0, "R2 arm sixth");
        step(1'b1, C_SW, 32'h0000_0600, 32'h6, 1'b1, C_LR, 32'h0000_0680, 32'h0, "R7 store hit with load-reserve");
        step(1'b1, C_SC, 32'h0000_0680, 32'h6666_0000, 1'b1, C_LR, 32'h0000_0700, 32'h0, "R7 R3 sc with load-reserve");
        // Lane priority
        step(1'b1, C_LR, 32'h0000_0800, 32'h0, 1'b1, C_LR, 32'h0000_0804, 32'h0, "R8 highest load-reserve");
        step(1'b1, C_SC, 32'h0000_0804, 32'h8888_0004, 1'b1, C_SC, 32'h0000_0900, 32'h9999_0000, "R8 lowest sc used");
        step(1'b1, C_LR, 32'h0000_0A00, 32'h0, 1'b0, 6'h00, 32'h0, 32'h0, "R2 arm seventh");
        step(1'b0, 6'h00, 32'h0, 32'h0, 1'b1, C_SC, 32'h0000_0A00, 32'hAAAA_0000, "R8 lane one sc alone");
        // Unaligned reservation: masked store cannot match, exact sc can
        one(C_LR, 32'h0000_0B01, 32'h0, "R2 unaligned arm");
        one(C_SW, 32'h0000_0B00, 32'hB0, "R6 masked compare misses");
        one(C_SC, 32'h0000_0B01, 32'hBBBB_0001, "R3 exact unaligned success");
        one(C_SC, 32'h0000_0B01, 32'hBBBB_0002, "R5 second sc fails");
        idle("R9 final hold");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R9: %0d expected items never compared, expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule